// File: doc/BRIEF.md
# Main instruction control decoder

This block turns the 6-bit major opcode of a fetched instruction into the steering signals that a single-cycle datapath needs. It chooses the destination register field, the second ALU operand, and the write-back source. It also sets the register file write enable, the data memory read and write strobes, a branch flag and a coarse 2-bit ALU operation class. The decoder is purely combinational. Its outputs are valid in the same cycle as the opcode.

Decoding happens in two levels. This level only states whether the ALU should add, subtract or follow the function field. A separate ALU control block turns that class and the function field into the actual ALU function code. The block also decides the next-PC source. It combines its own branch flag with the zero flag returned by the ALU, so a taken branch is known in the same cycle.

Internally the opcode is first sorted into one of five named classes. The classes are REG (register format), LOAD, STORE, BEQ and OTHER. Each class then selects one fixed control word. There are no states and no transitions: every path from an opcode to a control word is settled within the cycle.

Top module: `inst_ctrl_decoder`

## Requirements
- R1: Opcode 000000 (register format) gives dst_is_rd=1, alu_src_imm=0, wb_from_mem=0, reg_we=1, mem_re=0, mem_we=0, is_branch=0, alu_op=2'b10.
- R2: Opcode 100011 (load word) gives dst_is_rd=0, alu_src_imm=1, wb_from_mem=1, reg_we=1, mem_re=1, mem_we=0, is_branch=0, alu_op=2'b00.
- R3: Opcode 101011 (store word) gives alu_src_imm=1, mem_we=1, alu_op=2'b00 and all other control outputs 0. The don't-care outputs dst_is_rd and wb_from_mem are driven to 0.
- R4: Opcode 000100 (branch if equal) gives is_branch=1, alu_op=2'b01 and all other control outputs 0. The don't-care outputs dst_is_rd and wb_from_mem are driven to 0.
- R5: pc_take_target is 1 exactly when is_branch is 1 and alu_zero is 1, in the same cycle.
- R6: Any opcode other than the four above drives every output to 0. In particular there is no register write, no memory write and no branch.
- R7: mem_re and mem_we are never 1 together.
- R8: alu_zero has no effect on any output other than pc_take_target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Major opcode, instruction bits 31:26 |
| alu_zero | input | 1 | Zero flag from the ALU |
| dst_is_rd | output | 1 | 1: write register taken from bits 15:11; 0: from bits 20:16 |
| alu_src_imm | output | 1 | 1: second ALU operand is the sign-extended immediate |
| wb_from_mem | output | 1 | 1: write-back data comes from data memory |
| reg_we | output | 1 | Register file write enable |
| mem_re | output | 1 | Data memory read strobe |
| mem_we | output | 1 | Data memory write strobe |
| is_branch | output | 1 | Instruction is a conditional branch |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 use function field |
| pc_take_target | output | 1 | 1: next PC is the branch target |

## Verification
The branch decode and the next-PC selection act in the same cycle. A branch opcode raises is_branch, and that flag is gated at once by alu_zero to produce pc_take_target. The bench provokes this by driving every opcode with alu_zero both low and high. For each pair, the scoreboard holds expected values derived from the requirement tables. It then judges the full control word together with pc_take_target. Only the branch-if-equal opcode with a zero flag of 1 may raise pc_take_target. Every other opcode must give the same word for both zero values.

// File: rtl/inst_ctrl_pkg.sv
package inst_ctrl_pkg;

    localparam int OPC_W   = 6;
    localparam int ALUOP_W = 2;
    localparam int N_KNOWN = 4;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;

    localparam logic [ALUOP_W-1:0] AOP_ADD  = 2'b00;
    localparam logic [ALUOP_W-1:0] AOP_SUB  = 2'b01;
    localparam logic [ALUOP_W-1:0] AOP_FUNC = 2'b10;

    typedef enum logic [2:0] {
        CLS_REG   = 3'd0,
        CLS_LOAD  = 3'd1,
        CLS_STORE = 3'd2,
        CLS_BEQ   = 3'd3,
        CLS_OTHER = 3'd4
    } op_class_e;

    typedef struct packed {
        logic               dst_rd;
        logic               src_imm;
        logic               wb_mem;
        logic               reg_we;
        logic               mem_re;
        logic               mem_we;
        logic               branch;
        logic [ALUOP_W-1:0] alu_op;
    } ctrl_word_t;

    localparam ctrl_word_t CTRL_SAFE = '0;

endpackage

// File: rtl/opc_classify.sv
module opc_classify
    import inst_ctrl_pkg::*;
#(
    parameter int W = OPC_W
) (
    input  logic [W-1:0] opcode,
    output op_class_e    op_class
);

    localparam logic [W-1:0] KNOWN [N_KNOWN] = '{OPC_REG, OPC_LOAD, OPC_STORE, OPC_BEQ};

    logic [N_KNOWN-1:0] hit;

    for (genvar g = 0; g < N_KNOWN; g++) begin : g_match
        assign hit[g] = (opcode == KNOWN[g]);
    end

    always_comb begin
        unique case (1'b1)
            hit[0]:  op_class = CLS_REG;
            hit[1]:  op_class = CLS_LOAD;
            hit[2]:  op_class = CLS_STORE;
            hit[3]:  op_class = CLS_BEQ;
            default: op_class = CLS_OTHER;
        endcase
    end

endmodule

// File: rtl/ctrl_table.sv
module ctrl_table
    import inst_ctrl_pkg::*;
(
    input  op_class_e  op_class,
    output ctrl_word_t ctrl
);

    always_comb begin
        ctrl = CTRL_SAFE;
        unique case (op_class)
            CLS_REG: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = AOP_FUNC;
            end
            CLS_LOAD: begin
                ctrl.src_imm = 1'b1;
                ctrl.wb_mem  = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.mem_re  = 1'b1;
                ctrl.alu_op  = AOP_ADD;
            end
            CLS_STORE: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
                ctrl.alu_op  = AOP_ADD;
            end
            CLS_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = AOP_SUB;
            end
            default: ctrl = CTRL_SAFE;
        endcase
    end

    always_comb begin
        AST_RD_WR_EXCL: assert (!(ctrl.mem_re && ctrl.mem_we)) else $error("mem read and write together"); // R7
    end

endmodule

// File: rtl/pc_select.sv
module pc_select (
    input  logic branch,
    input  logic alu_zero,
    output logic take_target
);

    assign take_target = branch & alu_zero;

endmodule

// File: rtl/inst_ctrl_decoder.sv
module inst_ctrl_decoder
    import inst_ctrl_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic       alu_zero,
    output logic       dst_is_rd,
    output logic       alu_src_imm,
    output logic       wb_from_mem,
    output logic       reg_we,
    output logic       mem_re,
    output logic       mem_we,
    output logic       is_branch,
    output logic [1:0] alu_op,
    output logic       pc_take_target
);

    op_class_e  cls;
    ctrl_word_t cw;

    opc_classify #(.W(OPC_W)) u_classify (
        .opcode   (opcode),
        .op_class (cls)
    );

    ctrl_table u_table (
        .op_class (cls),
        .ctrl     (cw)
    );

    pc_select u_pcsel (
        .branch      (cw.branch),
        .alu_zero    (alu_zero),
        .take_target (pc_take_target)
    );

    assign dst_is_rd   = cw.dst_rd;
    assign alu_src_imm = cw.src_imm;
    assign wb_from_mem = cw.wb_mem;
    assign reg_we      = cw.reg_we;
    assign mem_re      = cw.mem_re;
    assign mem_we      = cw.mem_we;
    assign is_branch   = cw.branch;
    assign alu_op      = cw.alu_op;

    logic known_opc;
    assign known_opc = (opcode == OPC_REG) || (opcode == OPC_LOAD) ||
                       (opcode == OPC_STORE) || (opcode == OPC_BEQ);

    always_comb begin
        AST_UNKNOWN_SAFE: assert (known_opc || (cw == CTRL_SAFE && !pc_take_target)) else $error("unknown opcode not safe"); // R6
        AST_REGWR_FORMS: assert (!reg_we || opcode == OPC_REG || opcode == OPC_LOAD) else $error("bad register write"); // R1
        AST_TAKE_NEEDS_BR: assert (!pc_take_target || (opcode == OPC_BEQ && alu_zero)) else $error("bad pc take"); // R5
        AST_STORE_NO_WB: assert (!(opcode == OPC_STORE) || (!reg_we && mem_we)) else $error("store control wrong"); // R3
    end

endmodule

// File: tb/inst_ctrl_decoder_tb_top.sv
module inst_ctrl_decoder_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [5:0] opcode;
    logic       alu_zero;
    logic       dst_is_rd, alu_src_imm, wb_from_mem, reg_we, mem_re, mem_we, is_branch, pc_take_target;
    logic [1:0] alu_op;

    inst_ctrl_decoder dut_i (
        .opcode         (opcode),
        .alu_zero       (alu_zero),
        .dst_is_rd      (dst_is_rd),
        .alu_src_imm    (alu_src_imm),
        .wb_from_mem    (wb_from_mem),
        .reg_we         (reg_we),
        .mem_re         (mem_re),
        .mem_we         (mem_we),
        .is_branch      (is_branch),
        .alu_op         (alu_op),
        .pc_take_target (pc_take_target)
    );

    typedef struct {
        logic [5:0] opc;
        logic       z;
        logic [9:0] exp;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    // expected word: {dst, src, wbmem, we, re, mwe, br, aluop[1:0], pc}
    function automatic logic [9:0] model(input logic [5:0] o, input logic z);
        case (o)
            6'b000000: return {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0}; // R1
            6'b100011: return {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0}; // R2
            6'b101011: return {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0}; // R3
            6'b000100: return {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, z};    // R4 R5
            default:   return 10'b0;                                                    // R6
        endcase
    endfunction

    function automatic string tag(input logic [5:0] o, input logic z);
        case (o)
            6'b000000: return z ? "R1/R8" : "R1";
            6'b100011: return z ? "R2/R8" : "R2";
            6'b101011: return z ? "R3/R8" : "R3";
            6'b000100: return "R4/R5";
            default:   return z ? "R6/R8" : "R6";
        endcase
    endfunction

    task automatic drive(input logic [5:0] o, input logic z);
        item_t it;
        @(posedge clk);
        #1;
        opcode   = o;
        alu_zero = z;
        it.opc = o;
        it.z   = z;
        it.exp = model(o, z);
        sb_q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            logic [9:0] act;
            it  = sb_q.pop_front();
            act = {dst_is_rd, alu_src_imm, wb_from_mem, reg_we, mem_re, mem_we, is_branch, alu_op, pc_take_target};
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s opc=%b z=%b actual=%b expected=%b", tag(it.opc, it.z), it.opc, it.z, act, it.exp);
            end
            checks++;
            if (mem_re && mem_we) begin
                fails++;
                $display("FAIL R7 opc=%b actual re=%b we=%b expected not both", it.opc, mem_re, mem_we);
            end
        end
    end

    initial begin
        opcode   = 6'b111111;
        alu_zero = 1'b1;
        repeat (2) @(posedge clk);
        #5;
        // reset-time state: unknown opcode must be fully safe (R6)
        checks++;
        if ({dst_is_rd, alu_src_imm, wb_from_mem, reg_we, mem_re, mem_we, is_branch, alu_op, pc_take_target} !== 10'b0) begin
            fails++;
            $display("FAIL R6 reset-time outputs actual nonzero expected=0");
        end
        rst_n = 1'b1;
        // focused corners: branch taken and not taken (R5), back to back
        drive(6'b000100, 1'b1);
        drive(6'b000100, 1'b0);
        drive(6'b000000, 1'b1);
        drive(6'b100011, 1'b0);
        drive(6'b101011, 1'b1);
        drive(6'b000101, 1'b1);
        // sweep every opcode with both zero values
        for (int o = 0; o < 64; o++) begin
            for (int z = 0; z < 2; z++) begin
                drive(6'(o), 1'(z));
            end
        end
        @(posedge clk);
        @(posedge clk);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule